// File: doc/BRIEF.md
# Stateful Pattern Event Correlator

This block sits behind a pattern matcher and turns its stream of match events into protocol-level conclusions. Each incoming event carries a flow number, the signature subset the match came from, and an event number. The block keeps one small state value per flow. For each event it performs a single lookup in a programmable transition table, addressed by the flow's current state and the event number. The lookup gives the flow's next state and, if enabled, a 32-bit report code, which is presented on a valid/ready output.

A typical rule recognises a request followed by its response. From the idle state, a request event moves the flow to a waiting state. In the waiting state, a response event emits report code 0x00000001 and returns the flow to idle. Flow state persists for as long as needed, so a sequence that is split across separate data units is still recognised. Each flow is bound to exactly one signature subset, and events from any other subset leave that flow untouched. Events are accepted one per cycle. The cost of handling an event does not depend on how many transitions are programmed.

Top module: `flow_event_correlator`

## Requirements
- R1: After reset every flow is in state 0 and bound to subset 0, `rptValid` is low and `inReady` is high.
- R2: A transition is programmed by writing `ruleData` to `ruleAddr = {state[7:4], event[3:0]}`. The fields of `ruleData` are: bit 37 = entry valid, bits 36:33 = next state, bit 32 = report enable, bits 31:0 = report code. A valid entry whose subset matches moves the flow to the programmed next state.
- R3: With (state 0, event 1) programmed to go to state 1, and (state 1, event 2) programmed to go to state 0 with report 0x00000001, the sequence event 1 then event 2 on one flow yields `rptCode` = 0x00000001.
- R4: An event that finds no valid entry for the flow's current state leaves that state unchanged and produces no report.
- R5: State is kept separately for each flow. Events of different flows may interleave, with idle gaps of any length between them, and a later event still continues from the flow's stored state.
- R6: `bindWe` binds flow `bindFlow` to subset `bindSub`. An event whose `inSub` differs from the flow's bound subset has no effect on state and produces no report.
- R7: `flowClear` returns flow `clearFlow` to state 0 at the next clock edge. The clear takes priority over an event that commits to the same flow on the same edge, and an event accepted on the same edge for that flow sees state 0.
- R8: One event is accepted per cycle. Back-to-back events on the same flow see each other's state updates, as if they were processed one at a time.
- R9: An event accepted at clock edge k produces its report at edge k+1. While `rptValid` is high and `rptReady` is low, the report and its code are held, `inReady` is low, and offered events are not taken.
- R10: A valid entry with report enable 0 changes state without producing a report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Event offered |
| inReady | output | 1 | Event accepted when high together with inValid |
| inFlow | input | 6 | Flow number of the event |
| inSub | input | 3 | Signature subset of the event |
| inEvt | input | 4 | Event number |
| rptValid | output | 1 | Report present |
| rptReady | input | 1 | Report consumed when high together with rptValid |
| rptCode | output | 32 | Report code |
| ruleWe | input | 1 | Transition table write strobe |
| ruleAddr | input | 8 | Table address {state, event} |
| ruleData | input | 38 | Table entry {valid, next, report enable, code} |
| bindWe | input | 1 | Subset binding write strobe |
| bindFlow | input | 6 | Flow being bound |
| bindSub | input | 3 | Subset bound to the flow |
| flowClear | input | 1 | Return one flow to state 0 |
| clearFlow | input | 6 | Flow to clear |

## Verification
An event driven before edge k is taken at edge k and its state is looked up. Its report, or the lack of one, is visible after edge k+1. The bench therefore holds each expected outcome in a two-deep delay line and compares it one falling edge after that second edge, in every cycle, idle or busy, so that a missing report and a spurious report are both caught. Clears and events are applied to the bench's own model in the order the edges commit them, which covers the same-edge clear and forwarding cases. The stall sequence is checked cycle by cycle while ready is low. Afterwards, a probe event shows whether an event offered during the stall was wrongly taken.

// File: rtl/fec_pkg.sv
package fec_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture a new event into the lookup stage
    logic commit;  // write the looked-up next state back to the flow
    logic fire;    // latch the looked-up report code
  } fec_strobe_t;
endpackage

// File: rtl/fec_ctrl.sv
module fec_ctrl
  import fec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic        rptReady,
  output logic        rptValid,
  input  logic        hit,
  input  logic        hitRpt,
  output fec_strobe_t strobe
);
  logic advance;
  logic s1Valid;

  // the whole pipe moves unless a report is waiting on the consumer
  assign advance = !rptValid || rptReady;
  assign inReady = advance;

  always_comb begin
    strobe.load   = advance && inValid;
    strobe.commit = advance && s1Valid && hit;
    strobe.fire   = advance && s1Valid && hit && hitRpt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      rptValid <= 1'b0;
    end else if (advance) begin
      s1Valid  <= inValid;
      rptValid <= strobe.fire;
    end
  end

  // a report only appears when an event occupied the lookup stage
  p_report_after_event_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rptValid) |-> $past(s1Valid));

  // an empty lookup stage on a moving pipe leaves no report behind
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!s1Valid && advance) |=> !rptValid);
endmodule

// File: rtl/fec_datapath.sv
module fec_datapath
  import fec_pkg::*;
#(
  parameter int FLOWS   = 64,
  parameter int STATE_W = 4,
  parameter int EVT_W   = 4,
  parameter int SUB_W   = 3,
  parameter int CODE_W  = 32,
  localparam int FLOW_W  = $clog2(FLOWS),
  localparam int RULE_AW = STATE_W + EVT_W,
  localparam int RULES   = 1 << RULE_AW,
  localparam int ENT_W   = 1 + STATE_W + 1 + CODE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  fec_strobe_t        strobe,
  input  logic [FLOW_W-1:0]  inFlow,
  input  logic [SUB_W-1:0]   inSub,
  input  logic [EVT_W-1:0]   inEvt,
  input  logic               ruleWe,
  input  logic [RULE_AW-1:0] ruleAddr,
  input  logic [ENT_W-1:0]   ruleData,
  input  logic               bindWe,
  input  logic [FLOW_W-1:0]  bindFlow,
  input  logic [SUB_W-1:0]   bindSub,
  input  logic               flowClear,
  input  logic [FLOW_W-1:0]  clearFlow,
  output logic               hit,
  output logic               hitRpt,
  output logic [CODE_W-1:0]  rptCode
);
  logic [ENT_W-1:0]   ruleTab  [RULES];
  logic [STATE_W-1:0] ctxState [FLOWS];
  logic [SUB_W-1:0]   ctxSub   [FLOWS];

  logic [FLOW_W-1:0]  s1Flow;
  logic [SUB_W-1:0]   s1Sub;
  logic [EVT_W-1:0]   s1Evt;
  logic [STATE_W-1:0] s1State;

  logic [ENT_W-1:0]   entry;
  logic               entValid;
  logic [STATE_W-1:0] entNext;
  logic [CODE_W-1:0]  entCode;

  // single lookup per event, independent of how many entries are programmed
  assign entry    = ruleTab[{s1State, s1Evt}];
  assign entValid = entry[ENT_W-1];
  assign entNext  = entry[CODE_W+1 +: STATE_W];
  assign hitRpt   = entry[CODE_W];
  assign entCode  = entry[CODE_W-1:0];
  assign hit      = entValid && (ctxSub[s1Flow] == s1Sub);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < RULES; i++) ruleTab[i] <= '0;
    end else if (ruleWe) begin
      ruleTab[ruleAddr] <= ruleData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < FLOWS; i++) ctxSub[i] <= '0;
    end else if (bindWe) begin
      ctxSub[bindFlow] <= bindSub;
    end
  end

  // flow context: a clear overrides a commit to the same flow
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < FLOWS; i++) ctxState[i] <= '0;
    end else begin
      if (strobe.commit) ctxState[s1Flow] <= entNext;
      if (flowClear)     ctxState[clearFlow] <= '0;
    end
  end

  // lookup stage capture, with forwarding of same-edge writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Flow  <= '0;
      s1Sub   <= '0;
      s1Evt   <= '0;
      s1State <= '0;
    end else if (strobe.load) begin
      s1Flow <= inFlow;
      s1Sub  <= inSub;
      s1Evt  <= inEvt;
      if (flowClear && clearFlow == inFlow)
        s1State <= '0;
      else if (strobe.commit && s1Flow == inFlow)
        s1State <= entNext;
      else
        s1State <= ctxState[inFlow];
    end else if (flowClear && clearFlow == s1Flow) begin
      s1State <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            rptCode <= '0;
    else if (strobe.fire) rptCode <= entCode;
  end

  p_commit_writes_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !(flowClear && clearFlow == s1Flow))
      |=> ctxState[$past(s1Flow)] == $past(entNext));

  p_clear_resets_r7: assert property (@(posedge clk) disable iff (!rstN)
    flowClear |=> ctxState[$past(clearFlow)] == '0);
endmodule

// File: rtl/flow_event_correlator.sv
module flow_event_correlator
  import fec_pkg::*;
#(
  parameter int FLOWS   = 64,
  parameter int STATE_W = 4,
  parameter int EVT_W   = 4,
  parameter int SUB_W   = 3,
  parameter int CODE_W  = 32,
  localparam int FLOW_W  = $clog2(FLOWS),
  localparam int RULE_AW = STATE_W + EVT_W,
  localparam int ENT_W   = 1 + STATE_W + 1 + CODE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [FLOW_W-1:0]  inFlow,
  input  logic [SUB_W-1:0]   inSub,
  input  logic [EVT_W-1:0]   inEvt,
  output logic               rptValid,
  input  logic               rptReady,
  output logic [CODE_W-1:0]  rptCode,
  input  logic               ruleWe,
  input  logic [RULE_AW-1:0] ruleAddr,
  input  logic [ENT_W-1:0]   ruleData,
  input  logic               bindWe,
  input  logic [FLOW_W-1:0]  bindFlow,
  input  logic [SUB_W-1:0]   bindSub,
  input  logic               flowClear,
  input  logic [FLOW_W-1:0]  clearFlow
);
  fec_strobe_t strobe;
  logic hit;
  logic hitRpt;

  fec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .rptReady(rptReady), .rptValid(rptValid),
    .hit(hit), .hitRpt(hitRpt), .strobe(strobe)
  );

  fec_datapath #(
    .FLOWS(FLOWS), .STATE_W(STATE_W), .EVT_W(EVT_W),
    .SUB_W(SUB_W), .CODE_W(CODE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .inFlow(inFlow), .inSub(inSub), .inEvt(inEvt),
    .ruleWe(ruleWe), .ruleAddr(ruleAddr), .ruleData(ruleData),
    .bindWe(bindWe), .bindFlow(bindFlow), .bindSub(bindSub),
    .flowClear(flowClear), .clearFlow(clearFlow),
    .hit(hit), .hitRpt(hitRpt), .rptCode(rptCode)
  );

  // a stalled report keeps both its strobe and its code
  p_code_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rptValid && !rptReady) |=> (rptValid && $stable(rptCode)));
endmodule

// File: tb/flow_event_correlator_tb.sv
`timescale 1ns/1ps
module flow_event_correlator_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [5:0]  inFlow = '0;
  logic [2:0]  inSub = '0;
  logic [3:0]  inEvt = '0;
  logic        rptValid;
  logic        rptReady = 1'b1;
  logic [31:0] rptCode;
  logic        ruleWe = 1'b0;
  logic [7:0]  ruleAddr = '0;
  logic [37:0] ruleData = '0;
  logic        bindWe = 1'b0;
  logic [5:0]  bindFlow = '0;
  logic [2:0]  bindSub = '0;
  logic        flowClear = 1'b0;
  logic [5:0]  clearFlow = '0;

  int nChk = 0;
  int nFail = 0;

  logic [3:0]  mState [64];
  logic [2:0]  mBind  [64];
  logic        expV1 = 0, expV2 = 0;
  logic [31:0] expC1 = '0, expC2 = '0;
  string       expT1 = "R1", expT2 = "R1";

  always #10 clk = ~clk;

  flow_event_correlator u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inFlow(inFlow), .inSub(inSub), .inEvt(inEvt),
    .rptValid(rptValid), .rptReady(rptReady), .rptCode(rptCode),
    .ruleWe(ruleWe), .ruleAddr(ruleAddr), .ruleData(ruleData),
    .bindWe(bindWe), .bindFlow(bindFlow), .bindSub(bindSub),
    .flowClear(flowClear), .clearFlow(clearFlow)
  );

  // the programmed rule set: {valid, next[3:0], report enable, code[31:0]}
  function automatic logic [37:0] ruleOf(input int s, input int e);
    logic [37:0] r;
    r = '0;
    if (s == 0 && e == 1) r = {1'b1, 4'd1, 1'b0, 32'h0};
    if (s == 1 && e == 2) r = {1'b1, 4'd0, 1'b1, 32'h0000_0001};
    if (s == 0 && e == 5) r = {1'b1, 4'd2, 1'b0, 32'h0};
    if (s == 2 && e == 6) r = {1'b1, 4'd3, 1'b0, 32'h0};
    if (s == 3 && e == 7) r = {1'b1, 4'd0, 1'b1, 32'h5A5A_0003};
    if (s == 1 && e == 9) r = {1'b1, 4'd1, 1'b1, 32'hBEEF_0009};
    return r;
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one cycle: compare outputs against the expectation from two cycles ago,
  // then drive this cycle's event / clear and update the model
  task automatic tick(input logic v, input int f, input int sub, input int evt,
                      input logic clr, input int cf, input string tag);
    logic [37:0] e;
    @(negedge clk);
    check(rptValid === expV2, expT2, "rptValid", {31'b0, rptValid}, {31'b0, expV2});
    if (expV2) check(rptCode === expC2, expT2, "rptCode", rptCode, expC2);
    expV2 = expV1; expC2 = expC1; expT2 = expT1;
    inValid = v; inFlow = 6'(f); inSub = 3'(sub); inEvt = 4'(evt);
    flowClear = clr; clearFlow = 6'(cf);
    expV1 = 1'b0; expC1 = '0; expT1 = tag;
    if (clr) mState[cf] = '0;
    if (v) begin
      e = ruleOf(int'(mState[f]), evt);
      if (e[37] && mBind[f] == 3'(sub)) begin
        mState[f] = e[36:33];
        if (e[32]) begin expV1 = 1'b1; expC1 = e[31:0]; end
      end
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic evt(input int f, input int sub, input int ev, input string tag);
    tick(1, f, sub, ev, 0, 0, tag);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin mState[i] = '0; mBind[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rptValid === 1'b0, "R1", "rptValid after reset", {31'b0, rptValid}, 32'h0);
    check(inReady === 1'b1, "R1", "inReady after reset", {31'b0, inReady}, 32'h1);
    // R1: fresh flow in state 0: event 1 then 2 reports without setup of state
    // (rules loaded next)

    // R2: program the whole table, every address
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      ruleWe = 1'b1; ruleAddr = 8'(a); ruleData = ruleOf(a >> 4, a & 15);
    end
    @(negedge clk) ruleWe = 1'b0;
    // R6: bindings
    @(negedge clk) begin bindWe = 1'b1; bindFlow = 6'd10; bindSub = 3'd3; end
    mBind[10] = 3'd3;
    @(negedge clk) begin bindFlow = 6'd40; bindSub = 3'd5; end
    mBind[40] = 3'd5;
    @(negedge clk) bindWe = 1'b0;

    idle(2, "R1");
    // R3: request then response, spaced
    evt(0, 0, 1, "R3"); idle(2, "R3");
    evt(0, 0, 2, "R3"); idle(3, "R3");
    // R8: back-to-back on one flow
    evt(3, 0, 1, "R8"); evt(3, 0, 2, "R8"); evt(3, 0, 1, "R8"); evt(3, 0, 2, "R8");
    evt(3, 0, 1, "R8"); evt(3, 0, 9, "R8"); evt(3, 0, 9, "R8"); evt(3, 0, 2, "R8");
    idle(3, "R8");
    // R5: interleaved flows with idle gaps between units
    evt(5, 0, 1, "R5"); idle(4, "R5"); evt(6, 0, 1, "R5"); idle(7, "R5");
    evt(5, 0, 2, "R5"); idle(1, "R5"); evt(6, 0, 2, "R5"); idle(3, "R5");
    // R4: events without entries leave state
    evt(7, 0, 2, "R4"); evt(7, 0, 14, "R4"); evt(7, 0, 1, "R4");
    evt(7, 0, 1, "R4"); evt(7, 0, 2, "R4"); idle(3, "R4");
    // R6: subset mismatch ignored
    evt(10, 3, 1, "R6"); evt(10, 0, 2, "R6"); evt(10, 4, 2, "R6");
    evt(10, 3, 2, "R6"); evt(40, 0, 1, "R6"); evt(40, 5, 2, "R6"); idle(3, "R6");
    // R7: clear between request and response, and clear on the same edge
    evt(11, 0, 1, "R7"); tick(0, 0, 0, 0, 1, 11, "R7"); evt(11, 0, 2, "R7");
    evt(12, 0, 1, "R7"); tick(1, 12, 0, 2, 1, 12, "R7");
    evt(13, 0, 1, "R7"); tick(0, 0, 0, 0, 1, 13, "R7"); idle(1, "R7");
    evt(13, 0, 2, "R7"); idle(3, "R7");
    // R10: non-reporting transitions
    evt(20, 0, 5, "R10"); evt(20, 0, 6, "R10"); evt(20, 0, 7, "R10"); idle(3, "R10");
    // R2: sweep of flows, events, subsets and clears
    for (int i = 0; i < 700; i++) begin
      int f, ev, sb, cf;
      int evs [8];
      evs = '{1, 2, 5, 6, 7, 9, 0, 3};
      f  = ((i / 2) * 5) % 12 + ((i % 97 == 0) ? 40 : 0);
      ev = evs[(i * 3 + i / 8) % 8];
      sb = int'(mBind[f]) ^ ((i % 9 == 0) ? 1 : 0);
      cf = ((i / 2) * 5) % 12;
      tick((i % 17) != 5, f, sb, ev, (i % 13) == 0, cf, "R2");
    end
    idle(3, "R2");

    // R9: stall handling
    @(negedge clk);
    check(rptValid === 1'b0, "R9", "drained", {31'b0, rptValid}, 32'h0);
    rptReady = 1'b0;
    inValid = 1'b1; inFlow = 6'd30; inSub = '0; inEvt = 4'd1; flowClear = 1'b0;
    @(negedge clk) inEvt = 4'd2;
    @(negedge clk) inValid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(rptValid === 1'b1, "R9", "held valid", {31'b0, rptValid}, 32'h1);
      check(rptCode === 32'h1, "R9", "held code", rptCode, 32'h1);
      check(inReady === 1'b0, "R9", "inReady stalled", {31'b0, inReady}, 32'h0);
      inValid = (k < 3); inFlow = 6'd31; inEvt = 4'd1;
    end
    rptReady = 1'b1; inValid = 1'b0;
    @(negedge clk);
    check(rptValid === 1'b0, "R9", "released", {31'b0, rptValid}, 32'h0);
    check(inReady === 1'b1, "R9", "ready back", {31'b0, inReady}, 32'h1);
    mState[30] = '0;
    expV1 = 0; expV2 = 0;
    // offered-but-stalled event on flow 31 must not have been taken
    evt(31, 0, 2, "R9"); idle(3, "R9");

    summary();
    $finish;
  end
endmodule